// File: doc/BRIEF.md
# SATA Host Out-of-Band Link Sequencer

This block runs the host end of the out-of-band handshake that brings a SATA serial link up. It sits next to a serial transceiver that produces and detects the analog bursts. On the transmit side it raises a reset-signal request or a wake-signal request. It holds that request until the transceiver pulses its finish strobe. It also drives the transmit electrical-idle control, so the lane stays at the common-mode level whenever the host has nothing to send.

On the receive side it watches the receiver's electrical-idle flag. The flag is low during a burst and high during the quiet gap between bursts. The block measures both burst and gap lengths in cycles of its own slow clock. It classifies the device's signalling as a reset/init signal or a wake signal once a minimum run of well-formed gaps has been seen.

A sequencer steps through these phases in order: issue reset, wait for the device's init, issue wake, wait for the device's wake, then wait for ALIGN primitives. Once ALIGN primitives arrive it declares the link up. Every waiting phase has its own timeout that sends it back to issuing reset. An init detection while the link is up tears the link down and starts the sequence again.

Top module: `sata_oob_host`

## Requirements
- R1: While `rst` is high (synchronous, active high), `tx_init_req`, `tx_wake_req` and `link_up` are 0 and `tx_elec_idle` is 1.
- R2: On the first clock after reset, `tx_init_req` rises. It stays high until `tx_done` is sampled high, and falls on the following clock.
- R3: A quiet gap (`rx_idle` high) whose length is 12 to 21 cycles inclusive counts as an init gap. Lengths of 11 or 22 do not.
- R4: A quiet gap of 4 to 7 cycles inclusive counts as a wake gap. Gaps of 3 or 8 cycles count as neither kind.
- R5: A burst (`rx_idle` low) is well formed when it lasts 4 to 8 cycles inclusive. A burst outside that window clears both gap runs.
- R6: `cominit_det` or `comwake_det` pulses for one cycle when the 4th consecutive gap of its kind ends. The run then starts again from zero. A gap of the other kind or an out-of-window gap clears the run.
- R7: An init detection while waiting for the device raises `tx_wake_req`, which is held until `tx_done`. A later wake detection enters the ALIGN wait. `align_seen` there raises `link_up`.
- R8: Each waiting phase times out after its parameterised number of cycles (`TMO_COMINIT`, `TMO_COMWAKE`, `TMO_ALIGN`) and raises `tx_init_req` again.
- R9: When a detection and the timeout expiry reach the sequencer in the same cycle, the detection wins. A detection arriving one cycle after the timeout is ignored.
- R10: With `link_up` high, an init detection drops `link_up` and raises `tx_init_req` on the next clock.
- R11: `tx_elec_idle` is high only while waiting for the device's init or wake signal, and is never high together with a transmit request.
- R12: The run-length counter saturates. A gap far longer than the counter range is never taken for an in-window gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Out-of-band sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_idle | input | 1 | Receiver electrical-idle flag, high in gaps |
| tx_done | input | 1 | Transceiver finish strobe for the current transmit request |
| align_seen | input | 1 | ALIGN primitives are being received |
| tx_init_req | output | 1 | Request to send the reset/init burst signal |
| tx_wake_req | output | 1 | Request to send the wake burst signal |
| tx_elec_idle | output | 1 | Transmit electrical-idle control |
| cominit_det | output | 1 | One-cycle pulse: device init signal recognised |
| comwake_det | output | 1 | One-cycle pulse: device wake signal recognised |
| link_up | output | 1 | Handshake complete, link ready |

## Verification
The sharpest overlap is an init detection reaching the sequencer in the same cycle that the init-wait timer expires. The bench provokes this by placing the end of the fourth qualifying gap so that the registered detection pulse lands exactly on the last waiting cycle. It judges the result by which request appears afterwards: the wake request means the detection won. The same stimulus shifted one cycle later must instead leave the reset request raised.

// File: rtl/sata_oob_pkg.sv
package sata_oob_pkg;

    typedef enum logic [2:0] {
        ST_RESET_ISSUE,
        ST_WAIT_COMINIT,
        ST_COMWAKE_ISSUE,
        ST_WAIT_COMWAKE,
        ST_WAIT_ALIGN,
        ST_READY
    } host_state_e;

    typedef enum logic [1:0] {
        GAP_NONE,
        GAP_INIT,
        GAP_WAKE
    } gap_kind_e;

    // A level run of rx_idle just ended; was_idle tells gap from burst
    typedef struct packed {
        logic ended;
        logic was_idle;
    } run_evt_t;

    function automatic logic in_window(input int unsigned len,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (len >= lo) && (len <= hi);
    endfunction

    function automatic gap_kind_e gap_kind(input int unsigned len,
                                           input int unsigned init_lo,
                                           input int unsigned init_hi,
                                           input int unsigned wake_lo,
                                           input int unsigned wake_hi);
        if (in_window(len, init_lo, init_hi)) return GAP_INIT;
        if (in_window(len, wake_lo, wake_hi)) return GAP_WAKE;
        return GAP_NONE;
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/oob_run_meter.sv
module oob_run_meter
    import sata_oob_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_idle,
    output run_evt_t         evt,
    output logic [CNT_W-1:0] run_len
);
    logic             idle_q;
    logic [CNT_W-1:0] cnt;

    // cnt = cycles spent at level idle_q; 0 means unknown (just after reset)
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= 1'b1;
            cnt    <= '0;
        end else begin
            idle_q <= rx_idle;
            if (rx_idle != idle_q)
                cnt <= CNT_W'(1);
            else if (cnt != {CNT_W{1'b1}})
                cnt <= cnt + CNT_W'(1);
        end
    end

    assign evt.ended    = (rx_idle != idle_q);
    assign evt.was_idle = idle_q;
    assign run_len      = cnt;

endmodule

// File: rtl/oob_gap_classifier.sv
module oob_gap_classifier
    import sata_oob_pkg::*;
#(
    parameter int unsigned CNT_W     = 6,
    parameter int unsigned MIN_INIT  = 12,
    parameter int unsigned MAX_INIT  = 21,
    parameter int unsigned MIN_WAKE  = 4,
    parameter int unsigned MAX_WAKE  = 7,
    parameter int unsigned MIN_BURST = 4,
    parameter int unsigned MAX_BURST = 8,
    parameter int unsigned RUN_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  run_evt_t         evt,
    input  logic [CNT_W-1:0] run_len,
    output logic             init_det,
    output logic             wake_det
);
    localparam int unsigned RUN_W = $clog2(RUN_LEN + 1);
    localparam int unsigned NKIND = 2;

    gap_kind_e        kind;
    logic             burst_ok;
    logic             clear_all;
    logic [NKIND-1:0] qual;
    logic [NKIND-1:0] det_q;

    always_comb begin
        kind      = gap_kind(32'(run_len), MIN_INIT, MAX_INIT, MIN_WAKE, MAX_WAKE);
        burst_ok  = in_window(32'(run_len), MIN_BURST, MAX_BURST);
        qual[0]   = evt.ended && evt.was_idle && (kind == GAP_INIT);
        qual[1]   = evt.ended && evt.was_idle && (kind == GAP_WAKE);
        // any ended gap clears the runs it does not extend; a bad burst clears all
        clear_all = evt.ended && (evt.was_idle || !burst_ok);
    end

    for (genvar k = 0; k < NKIND; k++) begin : g_run
        logic [RUN_W-1:0] run;
        always_ff @(posedge clk) begin
            if (rst) begin
                run      <= '0;
                det_q[k] <= 1'b0;
            end else begin
                det_q[k] <= 1'b0;
                if (qual[k]) begin
                    if (run == RUN_W'(RUN_LEN - 1)) begin
                        run      <= '0;
                        det_q[k] <= 1'b1;
                    end else begin
                        run <= run + RUN_W'(1);
                    end
                end else if (clear_all) begin
                    run <= '0;
                end
            end
        end
    end

    assign init_det = det_q[0];
    assign wake_det = det_q[1];

endmodule

// File: rtl/oob_host_fsm.sv
module oob_host_fsm
    import sata_oob_pkg::*;
#(
    parameter int unsigned TMO_COMINIT = 1000,
    parameter int unsigned TMO_COMWAKE = 1000,
    parameter int unsigned TMO_ALIGN   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_done,
    input  logic align_seen,
    input  logic init_det,
    input  logic wake_det,
    output logic tx_init_req,
    output logic tx_wake_req,
    output logic tx_elec_idle,
    output logic link_up
);
    localparam int unsigned TMR_W = $clog2(max3(TMO_COMINIT, TMO_COMWAKE, TMO_ALIGN) + 1);

    host_state_e      state, nxt;
    logic [TMR_W-1:0] timer;
    logic             tmo;

    always_comb begin
        unique case (state)
            ST_WAIT_COMINIT: tmo = (timer == TMR_W'(TMO_COMINIT - 1));
            ST_WAIT_COMWAKE: tmo = (timer == TMR_W'(TMO_COMWAKE - 1));
            ST_WAIT_ALIGN:   tmo = (timer == TMR_W'(TMO_ALIGN - 1));
            default:         tmo = 1'b0;
        endcase
    end

    // detections are tested before the timeout so they win a same-cycle tie
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RESET_ISSUE:   if (tx_done) nxt = ST_WAIT_COMINIT;
            ST_WAIT_COMINIT:  if (init_det) nxt = ST_COMWAKE_ISSUE;
                              else if (tmo) nxt = ST_RESET_ISSUE;
            ST_COMWAKE_ISSUE: if (tx_done) nxt = ST_WAIT_COMWAKE;
            ST_WAIT_COMWAKE:  if (wake_det) nxt = ST_WAIT_ALIGN;
                              else if (tmo) nxt = ST_RESET_ISSUE;
            ST_WAIT_ALIGN:    if (align_seen) nxt = ST_READY;
                              else if (tmo) nxt = ST_RESET_ISSUE;
            ST_READY:         if (init_det) nxt = ST_RESET_ISSUE;
            default:          nxt = ST_RESET_ISSUE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_RESET_ISSUE;
            timer        <= '0;
            tx_init_req  <= 1'b0;
            tx_wake_req  <= 1'b0;
            tx_elec_idle <= 1'b1;
            link_up      <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != state)
                timer <= '0;
            else if (timer != {TMR_W{1'b1}})
                timer <= timer + TMR_W'(1);
            tx_init_req  <= (nxt == ST_RESET_ISSUE);
            tx_wake_req  <= (nxt == ST_COMWAKE_ISSUE);
            tx_elec_idle <= (nxt == ST_WAIT_COMINIT) || (nxt == ST_WAIT_COMWAKE);
            link_up      <= (nxt == ST_READY);
        end
    end

endmodule

// File: rtl/sata_oob_host.sv
module sata_oob_host
    import sata_oob_pkg::*;
#(
    parameter int unsigned MIN_INIT    = 12,
    parameter int unsigned MAX_INIT    = 21,
    parameter int unsigned MIN_WAKE    = 4,
    parameter int unsigned MAX_WAKE    = 7,
    parameter int unsigned MIN_BURST   = 4,
    parameter int unsigned MAX_BURST   = 8,
    parameter int unsigned RUN_LEN     = 4,
    parameter int unsigned TMO_COMINIT = 1000,
    parameter int unsigned TMO_COMWAKE = 1000,
    parameter int unsigned TMO_ALIGN   = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_idle,
    input  logic tx_done,
    input  logic align_seen,
    output logic tx_init_req,
    output logic tx_wake_req,
    output logic tx_elec_idle,
    output logic cominit_det,
    output logic comwake_det,
    output logic link_up
);
    // one spare bit above the largest window so saturation sits out of range
    localparam int unsigned CNT_W = $clog2(max3(MAX_INIT, MAX_WAKE, MAX_BURST) + 1) + 1;

    run_evt_t         evt;
    logic [CNT_W-1:0] run_len;

    oob_run_meter #(.CNT_W(CNT_W)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .rx_idle (rx_idle),
        .evt     (evt),
        .run_len (run_len)
    );

    oob_gap_classifier #(
        .CNT_W     (CNT_W),
        .MIN_INIT  (MIN_INIT),
        .MAX_INIT  (MAX_INIT),
        .MIN_WAKE  (MIN_WAKE),
        .MAX_WAKE  (MAX_WAKE),
        .MIN_BURST (MIN_BURST),
        .MAX_BURST (MAX_BURST),
        .RUN_LEN   (RUN_LEN)
    ) u_class (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .run_len  (run_len),
        .init_det (cominit_det),
        .wake_det (comwake_det)
    );

    oob_host_fsm #(
        .TMO_COMINIT (TMO_COMINIT),
        .TMO_COMWAKE (TMO_COMWAKE),
        .TMO_ALIGN   (TMO_ALIGN)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tx_done      (tx_done),
        .align_seen   (align_seen),
        .init_det     (cominit_det),
        .wake_det     (comwake_det),
        .tx_init_req  (tx_init_req),
        .tx_wake_req  (tx_wake_req),
        .tx_elec_idle (tx_elec_idle),
        .link_up      (link_up)
    );

endmodule

// File: rtl/sata_oob_host_chk.sv
module sata_oob_host_chk (
    input logic clk,
    input logic rst,
    input logic rx_idle,
    input logic tx_done,
    input logic tx_init_req,
    input logic tx_wake_req,
    input logic tx_elec_idle,
    input logic cominit_det,
    input logic comwake_det,
    input logic link_up
);
    assert_req_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_init_req, tx_wake_req}));

    assert_init_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (tx_init_req && !tx_done) |=> tx_init_req);

    assert_wake_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_wake_req && !tx_done) |=> tx_wake_req);

    assert_det_after_burst_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(cominit_det) |-> !$past(rx_idle));

    assert_det_single_R6: assert property (@(posedge clk) disable iff (rst)
        cominit_det |=> !cominit_det);

    assert_det_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(cominit_det && comwake_det));

    assert_link_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (link_up && cominit_det) |=> (!link_up && tx_init_req));

    assert_idle_vs_req_R11: assert property (@(posedge clk) disable iff (rst)
        !(tx_elec_idle && (tx_init_req || tx_wake_req)));

endmodule

bind sata_oob_host sata_oob_host_chk u_chk (.*);

// File: tb/sata_oob_host_bench.sv
module sata_oob_host_bench;

    localparam int unsigned TMO_I = 120;
    localparam int unsigned TMO_W = 120;
    localparam int unsigned TMO_A = 60;
    localparam int unsigned WDOG  = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_idle = 1'b1;
    logic tx_done = 1'b0;
    logic align_seen = 1'b0;
    logic tx_init_req, tx_wake_req, tx_elec_idle, cominit_det, comwake_det, link_up;

    int checks = 0;
    int failures = 0;
    int n_init = 0;
    int n_wake = 0;

    always #4 clk = ~clk;

    sata_oob_host #(
        .TMO_COMINIT (TMO_I),
        .TMO_COMWAKE (TMO_W),
        .TMO_ALIGN   (TMO_A)
    ) u_sata_oob_host (
        .clk          (clk),
        .rst          (rst),
        .rx_idle      (rx_idle),
        .tx_done      (tx_done),
        .align_seen   (align_seen),
        .tx_init_req  (tx_init_req),
        .tx_wake_req  (tx_wake_req),
        .tx_elec_idle (tx_elec_idle),
        .cominit_det  (cominit_det),
        .comwake_det  (comwake_det),
        .link_up      (link_up)
    );

    always @(negedge clk) begin
        if (cominit_det) n_init++;
        if (comwake_det) n_wake++;
    end

    typedef struct packed {
        int unsigned burst;
        int unsigned gap;
        int unsigned ngaps;
        int unsigned exp_init;
        int unsigned exp_wake;
        int unsigned req;
    } vec_t;

    // R3 init window, R4 wake window, R5 burst window, R6 run length, R12 saturation
    localparam vec_t VEC [17] = '{
        '{6, 16, 4, 1, 0, 3},
        '{6, 12, 4, 1, 0, 3},
        '{6, 21, 4, 1, 0, 3},
        '{6, 11, 4, 0, 0, 3},
        '{6, 22, 4, 0, 0, 3},
        '{6,  5, 4, 0, 1, 4},
        '{6,  4, 4, 0, 1, 4},
        '{6,  7, 4, 0, 1, 4},
        '{6,  3, 4, 0, 0, 4},
        '{6,  8, 4, 0, 0, 4},
        '{4, 16, 4, 1, 0, 5},
        '{8, 16, 4, 1, 0, 5},
        '{3, 16, 4, 0, 0, 5},
        '{9, 16, 4, 0, 0, 5},
        '{6, 16, 3, 0, 0, 6},
        '{6, 16, 8, 2, 0, 6},
        '{6, 80, 4, 0, 0, 12}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic idle_v);
        @(negedge clk);
        rx_idle = idle_v;
        tx_done = 1'b0;
    endtask

    task automatic idle_steps(input int n);
        for (int i = 0; i < n; i++) step(1'b1);
    endtask

    task automatic pulse_done();
        @(negedge clk);
        rx_idle = 1'b1;
        tx_done = 1'b1;
    endtask

    task automatic send_pattern(input int unsigned b, input int unsigned g, input int unsigned ng);
        for (int k = 0; k <= int'(ng); k++) begin
            for (int i = 0; i < int'(b); i++) step(1'b0);
            if (k < int'(ng))
                for (int i = 0; i < int'(g); i++) step(1'b1);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_idle = 1'b1;
        tx_done = 1'b0;
        align_seen = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // reset, then drive the flow up to the ALIGN wait
    task automatic reach_align_wait();
        apply_reset();
        pulse_done();
        send_pattern(6, 16, 4);
        idle_steps(5);
        pulse_done();
        send_pattern(6, 5, 4);
        idle_steps(5);
    endtask

    initial begin : watchdog
        repeat (WDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int b_init;
        int b_wake;
        int s;

        // R1: outputs during reset
        repeat (3) @(negedge clk);
        check("R1", "tx_init_req in reset", tx_init_req, 0);
        check("R1", "tx_wake_req in reset", tx_wake_req, 0);
        check("R1", "tx_elec_idle in reset", tx_elec_idle, 1);
        check("R1", "link_up in reset", link_up, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R2", "tx_init_req after reset", tx_init_req, 1);
        check("R11", "tx_elec_idle with init request", tx_elec_idle, 0);

        // classification table, sequencer parked in reset-issue
        for (int v = 0; v < 17; v++) begin
            idle_steps(30);
            b_init = n_init;
            b_wake = n_wake;
            send_pattern(VEC[v].burst, VEC[v].gap, VEC[v].ngaps);
            idle_steps(30);
            check($sformatf("R%0d", VEC[v].req), $sformatf("vec %0d init pulses", v),
                  n_init - b_init, int'(VEC[v].exp_init));
            check($sformatf("R%0d", VEC[v].req), $sformatf("vec %0d wake pulses", v),
                  n_wake - b_wake, int'(VEC[v].exp_wake));
        end

        // R2: request still held without a finish strobe
        check("R2", "tx_init_req held", tx_init_req, 1);
        pulse_done();
        step(1'b1);
        check("R2", "tx_init_req dropped", tx_init_req, 0);
        check("R11", "tx_elec_idle waiting init", tx_elec_idle, 1);

        // R7: device init -> wake request -> wake wait -> align wait -> ready
        send_pattern(6, 16, 4);
        idle_steps(5);
        check("R7", "tx_wake_req raised", tx_wake_req, 1);
        check("R7", "tx_init_req low", tx_init_req, 0);
        check("R11", "tx_elec_idle with wake request", tx_elec_idle, 0);
        idle_steps(10);
        check("R7", "tx_wake_req held", tx_wake_req, 1);
        pulse_done();
        step(1'b1);
        check("R7", "tx_wake_req dropped", tx_wake_req, 0);
        check("R11", "tx_elec_idle waiting wake", tx_elec_idle, 1);
        send_pattern(6, 5, 4);
        idle_steps(5);
        check("R7", "link_up before align", link_up, 0);
        check("R11", "tx_elec_idle in align wait", tx_elec_idle, 0);
        check("R7", "no request in align wait", tx_init_req | tx_wake_req, 0);
        @(negedge clk);
        align_seen = 1'b1;
        @(negedge clk);
        @(negedge clk);
        align_seen = 1'b0;
        check("R7", "link_up after align", link_up, 1);

        // R10: device init while ready
        send_pattern(6, 16, 4);
        idle_steps(3);
        check("R10", "link_up dropped", link_up, 0);
        check("R10", "tx_init_req reissued", tx_init_req, 1);

        // R8: exact init-wait timeout
        pulse_done();
        idle_steps(TMO_I);
        check("R8", "tx_init_req before timeout", tx_init_req, 0);
        step(1'b1);
        check("R8", "tx_init_req at timeout", tx_init_req, 1);

        // R9: detection lands on the last waiting cycle -> detection wins
        s = TMO_I - 1 - 88;
        pulse_done();
        idle_steps(s - 1);
        send_pattern(6, 16, 4);
        idle_steps(3);
        check("R9", "tie: tx_wake_req", tx_wake_req, 1);
        check("R9", "tie: tx_init_req", tx_init_req, 0);

        // R9: detection one cycle late -> timeout already taken
        apply_reset();
        pulse_done();
        idle_steps(s);
        send_pattern(6, 16, 4);
        idle_steps(3);
        check("R9", "late: tx_init_req", tx_init_req, 1);
        check("R9", "late: tx_wake_req", tx_wake_req, 0);

        // R8: ALIGN wait timeout
        reach_align_wait();
        check("R8", "align wait entered", tx_init_req | tx_wake_req | link_up, 0);
        idle_steps(TMO_A + 5);
        check("R8", "align timeout tx_init_req", tx_init_req, 1);
        check("R8", "align timeout link_up", link_up, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule